// File: doc/BRIEF.md
# SPI Chip-Select Delay Timer

This block times the two waits that an SPI master inserts around each frame. The first is the lead wait, from driving chip-select active to the first serial clock edge. The second is the trail wait, the idle gap held after a frame completes before the next one may start. Each wait has its own pair of configuration fields: an odd multiplier and a power-of-two scaler. The wait length in system clock cycles is the product of the two values.

The controller selects which wait it wants and pulses the start input. The block captures the length at that moment and counts system clock cycles. It then raises a one-cycle done pulse and returns to idle. An abort input cancels a running wait without producing done. Because the fields are captured per start, consecutive frames may use different waits.

Top module: `cs_delay_gen`

## Requirements
- R1: The wait length N in cycles is M×S. M comes from the 2-bit multiplier code c as M = 2c+1, so 00→1, 01→3, 10→5 and 11→7. S comes from the 4-bit scaler code n as S = 2^(n+1), giving 2 to 65536.
- R2: When `kind_i` is 0 the lead fields (`lead_mul_i`, `lead_scl_i`) set N. When it is 1 the trail fields (`trail_mul_i`, `trail_scl_i`) set N.
- R3: The cycle counter is 19 bits wide. It never exceeds the captured length, even at the largest setting of 7×65536 = 458752 cycles.
- R4: `done_o` is high for exactly one cycle. It rises N clock edges after the edge that accepted start: if start is accepted at edge E0, done is high between edge E0+N and edge E0+N+1.
- R5: `busy_o` is high from the edge that accepts start through the cycle in which done is high. It is low from the next edge on.
- R6: The select input and the configuration fields are sampled only on the accepting edge. Changing them later does not alter the running wait.
- R7: A start that arrives while `busy_o` is high is ignored, including during the done cycle. It neither restarts nor lengthens the wait.
- R8: A high `abort_i` at an edge returns the block to idle (busy and done low) without a done pulse. When abort and start are high together, abort wins.
- R9: After a synchronous active-low reset, `busy_o` and `done_o` are low.
- R10: A start presented once `busy_o` has dropped is accepted, so waits can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin a wait; only accepted while idle |
| kind_i | input | 1 | Wait type: 0 lead, 1 trail |
| lead_mul_i | input | 2 | Lead-wait multiplier code |
| lead_scl_i | input | 4 | Lead-wait scaler code |
| trail_mul_i | input | 2 | Trail-wait multiplier code |
| trail_scl_i | input | 4 | Trail-wait scaler code |
| abort_i | input | 1 | Synchronous cancel of a running wait |
| busy_o | output | 1 | A wait is in progress |
| done_o | output | 1 | One-cycle pulse at wait expiry |

## Verification
Several rules are checked by the assertions on every cycle: done lasts a single cycle and only occurs while busy, busy drops right after done, the counter stays within the captured length, the length stays in range, the length is held while busy, and abort forces idle. Other rules can only be shown by the bench's scenarios. These are the exact cycle of done for a given code pair, the choice between lead and trail fields, and the blindness to field changes and stray starts after capture. The bench also shows that abort suppresses any later done.

// File: rtl/cs_dly_pkg.sv
// Package: shared widths and types for the chip-select delay timer.
// Assumes the multiplier is odd (2c+1) and the scaler is 2^(n+1).
package cs_dly_pkg;
    localparam int MUL_W     = 2;
    localparam int SCL_W     = 4;
    localparam int MUL_MAX   = 2 * (2 ** MUL_W) - 1;
    localparam int SHIFT_MAX = 2 ** SCL_W;
    localparam int LEN_MAX   = MUL_MAX * (2 ** SHIFT_MAX);
    localparam int CNT_W     = $clog2(LEN_MAX + 1);

    typedef enum logic {
        DLY_LEAD  = 1'b0,
        DLY_TRAIL = 1'b1
    } dly_kind_e;

    typedef struct packed {
        logic [MUL_W-1:0] mul;
        logic [SCL_W-1:0] scl;
    } dly_cfg_t;
endpackage

// File: rtl/cs_dly_sel.sv
// Module: picks the lead or trail configuration pair by wait kind.
// Assumes both field pairs are stable while start is presented.
module cs_dly_sel
    import cs_dly_pkg::*;
(
    input  dly_kind_e kind_i,
    input  dly_cfg_t  lead_i,
    input  dly_cfg_t  trail_i,
    output dly_cfg_t  cfg_o
);
    // Route the fields belonging to the requested wait.
    always_comb begin
        unique case (kind_i)
            DLY_TRAIL: cfg_o = trail_i;
            default:   cfg_o = lead_i;
        endcase
    end
endmodule

// File: rtl/cs_dly_len.sv
// Module: turns a multiplier/scaler code pair into a cycle count.
// Builds one shifted multiplier per scaler code, then indexes it.
// Assumes CNT_W covers the largest product.
module cs_dly_len
    import cs_dly_pkg::*;
#(
    parameter int LEN_W = CNT_W
) (
    input  dly_cfg_t         cfg_i,
    output logic [LEN_W-1:0] len_o
);
    localparam int N_SCL = 2 ** SCL_W;

    logic [LEN_W-1:0] mul_val;
    logic [LEN_W-1:0] by_scl [N_SCL];

    // Odd multiplier value 2c+1.
    always_comb mul_val = LEN_W'({cfg_i.mul, 1'b1});

    for (genvar g = 0; g < N_SCL; g++) begin : g_scl
        // Scaler code g multiplies by 2^(g+1).
        always_comb by_scl[g] = mul_val << (g + 1);
    end

    // Pick the product for the requested scaler code.
    always_comb len_o = by_scl[cfg_i.scl];
endmodule

// File: rtl/cs_dly_cnt.sv
// Module: captures a length on start and counts cycles to a done pulse.
// Done is high N edges after the accepting edge. Busy covers the done cycle.
// Abort has priority over all other activity.
module cs_dly_cnt
    import cs_dly_pkg::*;
#(
    parameter int LEN_W = CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             busy_o,
    output logic             done_o
);
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic             busy_q;
    logic             done_q;

    // Sequence idle -> counting -> done -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            len_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (abort_i) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (!busy_q) begin
            done_q <= 1'b0;
            if (start_i) begin
                cnt_q  <= LEN_W'(1);
                len_q  <= len_i;
                busy_q <= 1'b1;
            end
        end else if (done_q) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (cnt_q == len_q) begin
            done_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

    // R4: done is a single-cycle pulse.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R5: done only inside a busy window.
    p_done_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> busy_q);
    // R5: busy drops right after done.
    p_busy_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !busy_q);
    // R3: counter stays within the captured length.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= len_q));
    // R1: captured length lies in the legal range.
    p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (len_q >= LEN_W'(2) && len_q <= LEN_W'(LEN_MAX)));
    // R6, R7: captured length is held while busy.
    p_len_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(len_q));
    // R8: abort forces idle.
    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_q && !done_q));
    // R10: start while idle launches a wait.
    p_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && start_i && !abort_i) |=> (busy_q && !done_q));
endmodule

// File: rtl/cs_delay_gen.sv
// Module: top of the chip-select delay timer.
// Selects the lead or trail fields, converts them to a cycle count, and runs
// the counter. Synchronous active-low reset throughout.
module cs_delay_gen
    import cs_dly_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             kind_i,
    input  logic [MUL_W-1:0] lead_mul_i,
    input  logic [SCL_W-1:0] lead_scl_i,
    input  logic [MUL_W-1:0] trail_mul_i,
    input  logic [SCL_W-1:0] trail_scl_i,
    input  logic             abort_i,
    output logic             busy_o,
    output logic             done_o
);
    dly_cfg_t         lead_cfg;
    dly_cfg_t         trail_cfg;
    dly_cfg_t         sel_cfg;
    dly_kind_e        kind;
    logic [CNT_W-1:0] len;

    // Pack the port fields into configuration records.
    always_comb begin
        lead_cfg  = '{mul: lead_mul_i,  scl: lead_scl_i};
        trail_cfg = '{mul: trail_mul_i, scl: trail_scl_i};
        kind      = dly_kind_e'(kind_i);
    end

    cs_dly_sel u_sel (
        .kind_i  (kind),
        .lead_i  (lead_cfg),
        .trail_i (trail_cfg),
        .cfg_o   (sel_cfg)
    );

    cs_dly_len #(.LEN_W(CNT_W)) u_len (
        .cfg_i (sel_cfg),
        .len_o (len)
    );

    cs_dly_cnt #(.LEN_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .abort_i (abort_i),
        .len_i   (len),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );
endmodule

// File: tb/tb_cs_delay_gen.sv
// Bench: seeded random and directed waits, checked against computed lengths.
module tb_cs_delay_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       kind_i = 1'b0;
    logic [1:0] lead_mul_i = '0;
    logic [3:0] lead_scl_i = '0;
    logic [1:0] trail_mul_i = '0;
    logic [3:0] trail_scl_i = '0;
    logic       abort_i = 1'b0;
    logic       busy_o;
    logic       done_o;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    cs_delay_gen dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
        .lead_mul_i(lead_mul_i), .lead_scl_i(lead_scl_i),
        .trail_mul_i(trail_mul_i), .trail_scl_i(trail_scl_i),
        .abort_i(abort_i), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic int exp_len(input logic [1:0] m, input logic [3:0] s);
        return (2 * int'(m) + 1) * (2 ** (int'(s) + 1));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Runs one wait. poke_at >= 0 pulses a stray start at that offset (R7).
    task automatic run_delay(input logic kind, input logic [1:0] lm, input logic [3:0] ls,
                             input logic [1:0] tm, input logic [3:0] ts, input int poke_at);
        int n;
        int done_at;
        int done_cnt;
        int busy_bad;
        n = exp_len(kind ? tm : lm, kind ? ts : ls);
        @(negedge clk);
        kind_i = kind; lead_mul_i = lm; lead_scl_i = ls;
        trail_mul_i = tm; trail_scl_i = ts; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R6: disturb every field after capture.
        kind_i = ~kind; lead_mul_i = 2'($urandom); lead_scl_i = 4'($urandom);
        trail_mul_i = 2'($urandom); trail_scl_i = 4'($urandom);
        done_at = -1; done_cnt = 0; busy_bad = -1;
        for (int j = 0; j <= n + 1; j++) begin
            if (done_o) begin
                done_cnt++;
                if (done_at < 0) done_at = j;
            end
            if (busy_o !== (j <= n) && busy_bad < 0) busy_bad = j;
            start_i = (j == poke_at);
            if (j == poke_at) begin lead_scl_i = 4'd0; trail_scl_i = 4'd0; end
            @(negedge clk);
        end
        start_i = 1'b0;
        check(done_at == n, "R1 R2 R4 R6 R7 done offset", done_at, n);
        check(done_cnt == 1, "R4 done width", done_cnt, 1);
        check(busy_bad < 0, "R5 busy window (first bad offset)", busy_bad, -1);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                check(1'b0, "watchdog", cycles, 190000);
                finish_run();
            end
        end
    end

    initial begin
        int dcnt;
        int bcnt;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state.
        check(busy_o === 1'b0, "R9 busy after reset", int'(busy_o), 0);
        check(done_o === 1'b0, "R9 done after reset", int'(done_o), 0);
        rst_n = 1'b1;

        // R1: shortest wait, lead select.
        run_delay(1'b0, 2'd0, 4'd0, 2'd3, 4'd5, -1);
        // R2: trail select, differing lead fields.
        run_delay(1'b1, 2'd3, 4'd6, 2'd1, 4'd2, -1);
        // R7: stray start during the done cycle (offset N = 5*8 = 40).
        run_delay(1'b0, 2'd2, 4'd2, 2'd0, 4'd0, 40);
        // R7: stray start early in a wait.
        run_delay(1'b1, 2'd0, 4'd0, 2'd3, 4'd3, 3);
        // R1 R3: long wait 7*8192.
        run_delay(1'b0, 2'd3, 4'd12, 2'd0, 4'd0, -1);
        // R10: back to back, no gap beyond busy drop.
        run_delay(1'b0, 2'd1, 4'd0, 2'd0, 4'd0, -1);

        // Random mix.
        for (int i = 0; i < 24; i++) begin
            logic k;
            logic [1:0] lm;
            logic [1:0] tm;
            logic [3:0] ls;
            logic [3:0] ts;
            int poke;
            k = 1'($urandom); lm = 2'($urandom); tm = 2'($urandom);
            ls = 4'($urandom_range(0, 7)); ts = 4'($urandom_range(0, 7));
            poke = ($urandom_range(0, 1) == 1) ? 1 : -1;
            run_delay(k, lm, ls, tm, ts, poke);
        end

        // R8: abort mid-wait, then no done.
        @(negedge clk);
        kind_i = 1'b0; lead_mul_i = 2'd3; lead_scl_i = 4'd5; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        check(busy_o === 1'b0, "R8 busy after abort", int'(busy_o), 0);
        dcnt = 0; bcnt = 0;
        for (int j = 0; j < 500; j++) begin
            if (done_o) dcnt++;
            if (busy_o) bcnt++;
            @(negedge clk);
        end
        check(dcnt == 0, "R8 no done after abort", dcnt, 0);
        check(bcnt == 0, "R8 stays idle after abort", bcnt, 0);

        // R8: abort wins over a simultaneous start.
        start_i = 1'b1; abort_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; abort_i = 1'b0;
        check(busy_o === 1'b0, "R8 abort beats start", int'(busy_o), 0);

        // R3: largest setting 7*65536 keeps counting without early done.
        lead_mul_i = 2'd3; lead_scl_i = 4'd15; kind_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        dcnt = 0; bcnt = 0;
        for (int j = 0; j < 2000; j++) begin
            if (done_o) dcnt++;
            if (!busy_o) bcnt++;
            @(negedge clk);
        end
        check(dcnt == 0 && bcnt == 0, "R3 max wait still running", dcnt + bcnt, 0);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        check(busy_o === 1'b0, "R8 abort of max wait", int'(busy_o), 0);

        // R10: fresh start right after abort is accepted.
        run_delay(1'b1, 2'd0, 4'd0, 2'd2, 4'd1, -1);

        finish_run();
    end
endmodule